// File: doc/BRIEF.md
# SPI Transfer Delay and Enable Controller

This block times the gaps around each transfer of a queued SPI master and holds the master's run bit. A control word contains three things: the run bit, a lead delay field and a trail delay field. When the queue sequencer asserts chip-select and signals that a transfer is about to start, the block can hold off the first serial clock edge. It counts system clocks for a length taken from the lead field. After a transfer ends, it can hold off the next transfer by a programmable trail delay. The trail delay is counted in units of 32 system clocks, and a zero field selects a fixed long gap.

Each queue entry carries two flags, one for the lead delay and one for the trail delay. When a flag is clear, the matching delay shrinks to a single system clock. The block reports which delay is running on a two-bit phase output. When a delay ends, it raises a one-clock done pulse for that delay. The run bit clears by itself in two cases: when the sequencer reports the whole queue complete, and when a mode fault occurs. A mode fault also cuts short any delay in progress.

Top module: `spi_dly_ctl`

## Requirements
- R1: After reset, `enable` is 0, `ctrl_word` reads 0x0404 (run bit 0, lead field 4, trail field 4), `phase` is 00 (idle) and both done pulses are low.
- R2: A write stores the whole control word. Bit 15 is the run bit, bits 14:8 are the lead field and bits 7:0 are the trail field. The stored word is visible on `ctrl_word` one clock after the write, and the run bit is visible on `enable`.
- R3: A `cs_valid` sampled while idle with `pre_req` high makes `phase` read 01 for exactly as many clocks as the lead field value (1 to 127). This starts in the cycle after the sampling edge.
- R4: A lead field of 0 gives a lead delay of 128 clocks.
- R5: An `xfer_done` sampled while idle with `post_req` high makes `phase` read 10 for exactly 32 × the trail field value clocks (trail field 1 to 255).
- R6: A trail field of 0 gives a trail delay of 8192 clocks.
- R7: When the flag sampled with the start (`pre_req` or `post_req`) is low, the delay lasts exactly one clock.
- R8: `pre_done` or `post_done` is high for exactly one clock, in the first cycle after the last cycle of the matching phase. It is never high while that phase is active.
- R9: Start requests are ignored while a delay is running, and they are ignored while the run bit is 0. `phase` does not change in response to them.
- R10: A mode fault clears `enable` at the next edge, even against a write of a 1 in the same cycle. It also returns `phase` to idle at that edge, and the aborted delay raises no done pulse.
- R11: `queue_done` clears `enable` at the next edge and leaves both delay fields unchanged.
- R12: When `cs_valid` and `xfer_done` are both sampled while idle, the trail delay starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cs_valid | input | 1 | Chip-select valid for the next transfer; requests a lead delay |
| pre_req | input | 1 | Lead delay flag of the current queue entry |
| xfer_done | input | 1 | Serial transfer finished; requests a trail delay |
| post_req | input | 1 | Trail delay flag of the current queue entry |
| queue_done | input | 1 | Every queued transfer is complete |
| mode_fault | input | 1 | Mode fault detected |
| ctrl_word | output | 16 | Current control word |
| enable | output | 1 | Run bit |
| phase | output | 2 | 00 idle, 01 lead delay, 10 trail delay |
| pre_done | output | 1 | One-clock pulse at the end of a lead delay |
| post_done | output | 1 | One-clock pulse at the end of a trail delay |

## Verification
The bench builds the block with its default parameters: a 7-bit lead field, an 8-bit trail field, a scale of 32 and a zero-field trail length of 8192. With these values, every end of both ranges runs in a short time. That covers lead values of 1, 127 and the 128-clock wrap, and trail values of 32 and 8160 clocks plus the 8192-clock zero case. Each run is measured cycle by cycle. Because the widest length sets the shared 14-bit counter, the 8192 case also exercises the counter's top bit.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_PRE  = 2'b01,
    PH_POST = 2'b10
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_dly_cfg.sv
module spi_dly_cfg #(
  parameter int PRE_W    = 7,
  parameter int POST_W   = 8,
  parameter int RST_PRE  = 4,
  parameter int RST_POST = 4,
  localparam int WORD_W  = 1 + PRE_W + POST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fault,
  input  logic              all_done,
  output logic              en,
  output logic [PRE_W-1:0]  pre_fld,
  output logic [POST_W-1:0] post_fld,
  output logic [WORD_W-1:0] word
);

  logic              en_d;
  logic [PRE_W-1:0]  pre_d;
  logic [POST_W-1:0] post_d;

  always_comb begin
    en_d   = en;
    pre_d  = pre_fld;
    post_d = post_fld;
    if (we) begin
      en_d   = wdata[WORD_W-1];
      pre_d  = wdata[WORD_W-2 -: PRE_W];
      post_d = wdata[POST_W-1:0];
    end
    if (fault || all_done) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      pre_fld  <= PRE_W'(RST_PRE);
      post_fld <= POST_W'(RST_POST);
    end else begin
      en       <= en_d;
      pre_fld  <= pre_d;
      post_fld <= post_d;
    end
  end

  assign word = {en, pre_fld, post_fld};

endmodule

// File: rtl/spi_dly_len.sv
module spi_dly_len #(
  parameter int PRE_W      = 7,
  parameter int POST_W     = 8,
  parameter int POST_SCALE = 32,
  parameter int POST_ZERO  = 8192,
  parameter int CNT_W      = 14
) (
  input  logic [PRE_W-1:0]  pre_fld,
  input  logic [POST_W-1:0] post_fld,
  input  logic              pre_req,
  input  logic              post_req,
  output logic [CNT_W-1:0]  pre_len,
  output logic [CNT_W-1:0]  post_len
);

  localparam int SCALE_SH = $clog2(POST_SCALE);
  localparam bit SCALE_P2 = ((POST_SCALE & (POST_SCALE - 1)) == 0);

  logic [CNT_W-1:0] post_scaled;

  generate
    if (SCALE_P2) begin : g_shift
      assign post_scaled = CNT_W'(post_fld) << SCALE_SH;
    end else begin : g_mult
      assign post_scaled = CNT_W'(post_fld) * CNT_W'(POST_SCALE);
    end
  endgenerate

  always_comb begin
    if (!pre_req) begin
      pre_len = CNT_W'(1);
    end else if (pre_fld == '0) begin
      pre_len = CNT_W'(1 << PRE_W);
    end else begin
      pre_len = CNT_W'(pre_fld);
    end

    if (!post_req) begin
      post_len = CNT_W'(1);
    end else if (post_fld == '0) begin
      post_len = CNT_W'(POST_ZERO);
    end else begin
      post_len = post_scaled;
    end
  end

endmodule

// File: rtl/spi_dly_timer.sv
module spi_dly_timer
  import spi_dly_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             pre_go,
  input  logic             post_go,
  input  logic [CNT_W-1:0] pre_len,
  input  logic [CNT_W-1:0] post_len,
  output phase_e           phase,
  output logic             pre_done,
  output logic             post_done
);

  phase_e           ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_done_d, post_done_d;
  logic             last;

  assign last = (cnt_q == CNT_W'(1));

  always_comb begin
    ph_d        = phase;
    cnt_d       = cnt_q;
    pre_done_d  = 1'b0;
    post_done_d = 1'b0;
    if (abort) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (post_go) begin
            ph_d  = PH_POST;
            cnt_d = post_len;
          end else if (pre_go) begin
            ph_d  = PH_PRE;
            cnt_d = pre_len;
          end
        end
        PH_PRE, PH_POST: begin
          if (last) begin
            ph_d        = PH_IDLE;
            cnt_d       = '0;
            pre_done_d  = (phase == PH_PRE);
            post_done_d = (phase == PH_POST);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt_q     <= '0;
      pre_done  <= 1'b0;
      post_done <= 1'b0;
    end else begin
      phase     <= ph_d;
      cnt_q     <= cnt_d;
      pre_done  <= pre_done_d;
      post_done <= post_done_d;
    end
  end

endmodule

// File: rtl/spi_dly_ctl.sv
module spi_dly_ctl
  import spi_dly_pkg::*;
#(
  parameter int PRE_W      = 7,
  parameter int POST_W     = 8,
  parameter int POST_SCALE = 32,
  parameter int POST_ZERO  = 8192,
  parameter int RST_PRE    = 4,
  parameter int RST_POST   = 4,
  localparam int WORD_W    = 1 + PRE_W + POST_W,
  localparam int LEN_MAX   = imax(imax(1 << PRE_W, POST_SCALE * ((1 << POST_W) - 1)), POST_ZERO),
  localparam int CNT_W     = $clog2(LEN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cs_valid,
  input  logic              pre_req,
  input  logic              xfer_done,
  input  logic              post_req,
  input  logic              queue_done,
  input  logic              mode_fault,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              enable,
  output logic [1:0]        phase,
  output logic              pre_done,
  output logic              post_done
);

  logic              rs_a, rs_b;
  logic [PRE_W-1:0]  pre_fld;
  logic [POST_W-1:0] post_fld;
  logic [CNT_W-1:0]  pre_len, post_len;
  phase_e            ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  spi_dly_cfg #(
    .PRE_W(PRE_W), .POST_W(POST_W), .RST_PRE(RST_PRE), .RST_POST(RST_POST)
  ) u_cfg (
    .clk(clk), .rst_n(rs_b), .we(cfg_we), .wdata(cfg_wdata),
    .fault(mode_fault), .all_done(queue_done),
    .en(enable), .pre_fld(pre_fld), .post_fld(post_fld), .word(ctrl_word)
  );

  spi_dly_len #(
    .PRE_W(PRE_W), .POST_W(POST_W), .POST_SCALE(POST_SCALE),
    .POST_ZERO(POST_ZERO), .CNT_W(CNT_W)
  ) u_len (
    .pre_fld(pre_fld), .post_fld(post_fld), .pre_req(pre_req), .post_req(post_req),
    .pre_len(pre_len), .post_len(post_len)
  );

  spi_dly_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rs_b), .abort(mode_fault || !enable),
    .pre_go(cs_valid), .post_go(xfer_done),
    .pre_len(pre_len), .post_len(post_len),
    .phase(ph), .pre_done(pre_done), .post_done(post_done)
  );

  assign phase = ph;

endmodule

// File: rtl/spi_dly_chk.sv
module spi_dly_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_valid,
  input logic       xfer_done,
  input logic       queue_done,
  input logic       mode_fault,
  input logic       enable,
  input logic [1:0] phase,
  input logic       pre_done,
  input logic       post_done
);

  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'b11);

  assert_pre_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_done |-> ($past(phase) == 2'b01 && phase != 2'b01));

  assert_post_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    post_done |-> ($past(phase) == 2'b10 && phase != 2'b10));

  assert_pulse_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_done || post_done) |=> !(pre_done || post_done));

  assert_busy_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01) |=> (phase != 2'b10));

  assert_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == 2'b00));

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> (!enable && phase == 2'b00 && !pre_done && !post_done));

  assert_qdone_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    queue_done |=> !enable);

  assert_both_post_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && enable && !mode_fault && cs_valid && xfer_done)
      |=> (phase == 2'b10));

endmodule

bind spi_dly_ctl spi_dly_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_valid(cs_valid), .xfer_done(xfer_done),
  .queue_done(queue_done), .mode_fault(mode_fault), .enable(enable),
  .phase(phase), .pre_done(pre_done), .post_done(post_done)
);

// File: tb/spi_dly_ctl_tb.sv
`timescale 1ns/1ps
module spi_dly_ctl_tb;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic        cs_valid, pre_req, xfer_done, post_req, queue_done, mode_fault;
  logic [15:0] ctrl_word;
  logic        enable, pre_done, post_done;
  logic [1:0]  phase;

  int vec_cnt = 0;
  int err_cnt = 0;

  spi_dly_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cs_valid(cs_valid), .pre_req(pre_req), .xfer_done(xfer_done),
    .post_req(post_req), .queue_done(queue_done), .mode_fault(mode_fault),
    .ctrl_word(ctrl_word), .enable(enable), .phase(phase),
    .pre_done(pre_done), .post_done(post_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      err_cnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input bit en, input int pre, input int post);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {en, 7'(pre), 8'(post)};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic run_delay(input bit is_post, input bit flag, input int exp, input string tag);
    int n = 0;
    int early = 0;
    logic [1:0] want;
    want = is_post ? 2'b10 : 2'b01;
    @(negedge clk);
    if (is_post) begin xfer_done = 1'b1; post_req = flag; end
    else         begin cs_valid  = 1'b1; pre_req  = flag; end
    @(negedge clk);
    xfer_done = 1'b0; cs_valid = 1'b0; pre_req = 1'b0; post_req = 1'b0;
    while (phase == want && n < 20000) begin
      if ((is_post ? post_done : pre_done) !== 1'b0) early++;
      n++;
      @(negedge clk);
    end
    chk({tag, " length"}, n, exp);
    chk("R8 no done while active", early, 0);
    chk("R8 done pulse high", int'(is_post ? post_done : pre_done), 1);
    @(negedge clk);
    chk("R8 done pulse one clock", int'(is_post ? post_done : pre_done), 0);
    chk("R8 idle after delay", int'(phase), 0);
  endtask

  task automatic t_reset;
    chk("R1 enable", int'(enable), 0);
    chk("R1 ctrl_word", int'(ctrl_word), 16'h0404);
    chk("R1 phase", int'(phase), 0);
    chk("R1 dones", int'(pre_done) + int'(post_done), 0);
  endtask

  task automatic t_layout;
    set_cfg(1'b1, 7'h0A, 8'h5C);
    chk("R2 readback", int'(ctrl_word), 16'h8A5C);
    chk("R2 enable", int'(enable), 1);
    set_cfg(1'b0, 7'h7F, 8'h01);
    chk("R2 readback off", int'(ctrl_word), 16'h7F01);
    chk("R2 enable off", int'(enable), 0);
  endtask

  task automatic t_pre;
    set_cfg(1'b1, 127, 4); run_delay(1'b0, 1'b1, 127, "R3 lead 127");
    set_cfg(1'b1, 1, 4);   run_delay(1'b0, 1'b1, 1,   "R3 lead 1");
    set_cfg(1'b1, 0, 4);   run_delay(1'b0, 1'b1, 128, "R4 lead zero");
    set_cfg(1'b1, 99, 4);  run_delay(1'b0, 1'b0, 1,   "R7 lead flag clear");
  endtask

  task automatic t_post;
    set_cfg(1'b1, 4, 1);   run_delay(1'b1, 1'b1, 32,   "R5 trail 1");
    set_cfg(1'b1, 4, 255); run_delay(1'b1, 1'b1, 8160, "R5 trail 255");
    set_cfg(1'b1, 4, 0);   run_delay(1'b1, 1'b1, 8192, "R6 trail zero");
    set_cfg(1'b1, 4, 200); run_delay(1'b1, 1'b0, 1,    "R7 trail flag clear");
  endtask

  task automatic t_busy;
    int n = 0;
    int stray = 0;
    set_cfg(1'b1, 10, 3);
    @(negedge clk); cs_valid = 1'b1; pre_req = 1'b1;
    @(negedge clk); cs_valid = 1'b0; pre_req = 1'b0;
    while (phase == 2'b01 && n < 100) begin
      n++;
      if (n == 3) begin
        xfer_done = 1'b1; post_req = 1'b1; cs_valid = 1'b1; pre_req = 1'b1;
      end else begin
        xfer_done = 1'b0; post_req = 1'b0; cs_valid = 1'b0; pre_req = 1'b0;
      end
      @(negedge clk);
    end
    xfer_done = 1'b0; post_req = 1'b0; cs_valid = 1'b0; pre_req = 1'b0;
    chk("R9 busy start ignored, lead length", n, 10);
    for (int i = 0; i < 3; i++) begin
      if (phase != 2'b00) stray++;
      @(negedge clk);
    end
    chk("R9 no late start", stray, 0);
    set_cfg(1'b0, 10, 3);
    cs_valid = 1'b1; pre_req = 1'b1; xfer_done = 1'b1; post_req = 1'b1;
    @(negedge clk);
    chk("R9 start ignored when off", int'(phase), 0);
    cs_valid = 1'b0; pre_req = 1'b0; xfer_done = 1'b0; post_req = 1'b0;
  endtask

  task automatic t_both;
    set_cfg(1'b1, 5, 2);
    @(negedge clk);
    cs_valid = 1'b1; pre_req = 1'b1; xfer_done = 1'b1; post_req = 1'b1;
    @(negedge clk);
    cs_valid = 1'b0; pre_req = 1'b0; xfer_done = 1'b0; post_req = 1'b0;
    chk("R12 trail wins", int'(phase), 2);
    repeat (70) @(negedge clk);
    chk("R12 back to idle", int'(phase), 0);
  endtask

  task automatic t_fault;
    int late = 0;
    set_cfg(1'b1, 4, 255);
    @(negedge clk); xfer_done = 1'b1; post_req = 1'b1;
    @(negedge clk); xfer_done = 1'b0; post_req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 running before fault", int'(phase), 2);
    mode_fault = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h84FF;
    @(negedge clk);
    mode_fault = 1'b0; cfg_we = 1'b0;
    chk("R10 enable cleared", int'(enable), 0);
    chk("R10 phase idle", int'(phase), 0);
    for (int i = 0; i < 40; i++) begin
      if (post_done || phase != 2'b00) late++;
      @(negedge clk);
    end
    chk("R10 no done after abort", late, 0);
  endtask

  task automatic t_qdone;
    set_cfg(1'b1, 33, 77);
    @(negedge clk); queue_done = 1'b1;
    @(negedge clk); queue_done = 1'b0;
    chk("R11 enable cleared", int'(enable), 0);
    chk("R11 fields kept", int'(ctrl_word), 16'h214D);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    cs_valid = 1'b0; pre_req = 1'b0; xfer_done = 1'b0; post_req = 1'b0;
    queue_done = 1'b0; mode_fault = 1'b0;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_layout;
    t_pre;
    t_post;
    t_busy;
    t_both;
    t_fault;
    t_qdone;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule